// File: doc/BRIEF.md
# Boot Fetch Address Selector

This block decides where the processor fetches its first instruction after reset. When reset is released it samples a boot pin and a set of option-byte fields: the security-enable bit, the boot-lock bit, a software boot-select bit, an option-byte boot bit, the readout-protection level, and three 25-bit boot addresses (two for the non-secure boot and one for the secure boot). From these it chooses a candidate address.

The candidate is then checked against the address window that the current protection level allows. When the check fails, a fixed fallback address takes its place. The result is registered together with a valid strobe. Both hold steady until the next reset, so later changes on the pin or the option fields have no effect on the fetch address.

Reset is taken asynchronously and released through a synchronizer. The capture happens on the first clock edge after the synchronized release.

Top module: `boot_fetch_sel`

## Requirements
- R1: With `sec_en`=0 and `sw_sel`=1, `boot_pin` decides the choice: 0 picks `ns_addr0` and 1 picks `ns_addr1`.
- R2: With `sec_en`=0 and `sw_sel`=0, `opt_boot` decides the choice: 1 picks `ns_addr0` and 0 picks `ns_addr1`.
- R3: With `sec_en`=1 and `boot_lock`=1, the secure address `s_addr` is used whatever the values of `sw_sel`, `opt_boot` and `boot_pin`.
- R4: With `sec_en`=1 and `boot_lock`=0, a selection value is formed as in R1/R2. A value of 0 picks `s_addr` and a value of 1 picks the secure services entry 0x0FF8_0000.
- R5: `prot_lvl` encodes the level as 00 = level 0, 01 = level 0.5, 10 = level 1 and 11 = level 2. With `sec_en`=1 and any level other than 00, the address must be 0x0FF8_0000 or lie in 0x0C00_0000..0x0C07_FFFF. Any other address becomes 0x0FF8_0000.
- R6: With `sec_en`=0 and `prot_lvl`=11, the address must lie in 0x0800_0000..0x0807_FFFF. Any other address becomes 0x0800_0000.
- R7: At `prot_lvl`=00, and with `sec_en`=0 at levels 01 and 10, the chosen address is used unchanged.
- R8: A 25-bit option address maps to bits [31:7] of `fetch_addr`, and bits [6:0] are zero.
- R9: While reset is active, `fetch_valid` and `fetch_addr` are 0. After `rst_n` rises, capture takes place on the third rising clock edge. From then on `fetch_valid` stays 1 and `fetch_addr` holds its value whatever the inputs do until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_en | input | 1 | Security enabled |
| boot_lock | input | 1 | Force the secure boot address |
| sw_sel | input | 1 | 1: boot pin decides, 0: option bit decides |
| opt_boot | input | 1 | Option-byte boot bit |
| boot_pin | input | 1 | Boot-select pin |
| prot_lvl | input | 2 | Readout-protection level (R5 encoding) |
| ns_addr0 | input | 25 | Non-secure boot address 0, bits [31:7] |
| ns_addr1 | input | 25 | Non-secure boot address 1, bits [31:7] |
| s_addr | input | 25 | Secure boot address, bits [31:7] |
| fetch_addr | output | 32 | First instruction fetch address |
| fetch_valid | output | 1 | Fetch address captured |

## Verification
The selection and window assertions compare the live inputs with the combinational candidate on every cycle. They therefore assume only that the inputs are known values while reset is inactive. The hold assertions assume nothing beyond a clean reset.

The stimulus changes inputs only at falling clock edges and always drives defined values. The random address fields are biased so that window edges, the fallback entries and arbitrary values all occur. Inputs are also scrambled after capture, which exercises the hold behaviour.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;

  typedef enum logic [1:0] {
    PL_OPEN = 2'b00,
    PL_HALF = 2'b01,
    PL_ONE  = 2'b10,
    PL_MAX  = 2'b11
  } prot_lvl_e;

  typedef struct packed {
    logic      sec_en;
    logic      lock;
    logic      sw_sel;
    logic      opt_boot;
    logic      pin;
    prot_lvl_e lvl;
  } boot_ctl_t;

endpackage

// File: rtl/bootsel_rst_sync.sv
module bootsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      always_comb chain_d[gi] = chain_q[gi-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/bootsel_choose.sv
module bootsel_choose
  import bootsel_pkg::*;
#(
  parameter int          OPT_W    = 25,
  parameter int          ADDR_W   = 32,
  parameter logic [31:0] RSS_ADDR = 32'h0FF8_0000
) (
  input  boot_ctl_t          ctl,
  input  logic [OPT_W-1:0]   ns0,
  input  logic [OPT_W-1:0]   ns1,
  input  logic [OPT_W-1:0]   sadr,
  output logic [ADDR_W-1:0]  chosen
);
  localparam int PAD = ADDR_W - OPT_W;

  logic sel_hi;
  logic [ADDR_W-1:0] ns0_w, ns1_w, s_w;

  assign ns0_w = {ns0,  {PAD{1'b0}}};
  assign ns1_w = {ns1,  {PAD{1'b0}}};
  assign s_w   = {sadr, {PAD{1'b0}}};

  always_comb begin
    sel_hi = ctl.sw_sel ? ctl.pin : ~ctl.opt_boot;
    if (!ctl.sec_en) begin
      chosen = sel_hi ? ns1_w : ns0_w;
    end else if (ctl.lock || !sel_hi) begin
      chosen = s_w;
    end else begin
      chosen = RSS_ADDR[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/bootsel_window.sv
module bootsel_window
  import bootsel_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter logic [31:0] RSS_ADDR     = 32'h0FF8_0000,
  parameter logic [31:0] SEC_WIN_BASE = 32'h0C00_0000,
  parameter logic [31:0] SEC_WIN_SIZE = 32'h0008_0000,
  parameter logic [31:0] NS_WIN_BASE  = 32'h0800_0000,
  parameter logic [31:0] NS_WIN_SIZE  = 32'h0008_0000
) (
  input  logic               sec_en,
  input  prot_lvl_e          lvl,
  input  logic [ADDR_W-1:0]  cand,
  output logic [ADDR_W-1:0]  checked
);
  localparam logic [31:0] SEC_LAST = SEC_WIN_BASE + SEC_WIN_SIZE - 32'd1;
  localparam logic [31:0] NS_LAST  = NS_WIN_BASE  + NS_WIN_SIZE  - 32'd1;

  logic in_sec, in_ns, is_rss;

  always_comb begin
    in_sec = (cand >= SEC_WIN_BASE[ADDR_W-1:0]) && (cand <= SEC_LAST[ADDR_W-1:0]);
    in_ns  = (cand >= NS_WIN_BASE[ADDR_W-1:0])  && (cand <= NS_LAST[ADDR_W-1:0]);
    is_rss = (cand == RSS_ADDR[ADDR_W-1:0]);
    checked = cand;
    if (sec_en) begin
      if (lvl != PL_OPEN && !(in_sec || is_rss)) checked = RSS_ADDR[ADDR_W-1:0];
    end else begin
      if (lvl == PL_MAX && !in_ns) checked = NS_WIN_BASE[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/bootsel_capture.sv
module bootsel_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [ADDR_W-1:0] cand,
  output logic [ADDR_W-1:0] addr_q,
  output logic              valid_q
);
  logic              cap_en;
  logic [ADDR_W-1:0] addr_d;
  logic              valid_d;

  always_comb begin
    cap_en  = ~valid_q;
    addr_d  = addr_q;
    valid_d = valid_q;
    if (cap_en) begin
      addr_d  = cand;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      valid_q <= valid_d;
    end
  end

  // R9
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    valid_q |=> valid_q);
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    valid_q |=> $stable(addr_q));
  // R9
  addr_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !valid_q |-> (addr_q == '0));
endmodule

// File: rtl/boot_fetch_sel.sv
module boot_fetch_sel
  import bootsel_pkg::*;
#(
  parameter int          OPT_W        = 25,
  parameter int          ADDR_W       = 32,
  parameter int          SYNC_STAGES  = 2,
  parameter logic [31:0] RSS_ADDR     = 32'h0FF8_0000,
  parameter logic [31:0] SEC_WIN_BASE = 32'h0C00_0000,
  parameter logic [31:0] SEC_WIN_SIZE = 32'h0008_0000,
  parameter logic [31:0] NS_WIN_BASE  = 32'h0800_0000,
  parameter logic [31:0] NS_WIN_SIZE  = 32'h0008_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_en,
  input  logic              boot_lock,
  input  logic              sw_sel,
  input  logic              opt_boot,
  input  logic              boot_pin,
  input  logic [1:0]        prot_lvl,
  input  logic [OPT_W-1:0]  ns_addr0,
  input  logic [OPT_W-1:0]  ns_addr1,
  input  logic [OPT_W-1:0]  s_addr,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_valid
);
  localparam int          PAD      = ADDR_W - OPT_W;
  localparam logic [31:0] SEC_LAST = SEC_WIN_BASE + SEC_WIN_SIZE - 32'd1;
  localparam logic [31:0] NS_LAST  = NS_WIN_BASE  + NS_WIN_SIZE  - 32'd1;

  logic              srst_n;
  boot_ctl_t         ctl;
  logic [ADDR_W-1:0] chosen;
  logic [ADDR_W-1:0] checked;

  always_comb begin
    ctl.sec_en   = sec_en;
    ctl.lock     = boot_lock;
    ctl.sw_sel   = sw_sel;
    ctl.opt_boot = opt_boot;
    ctl.pin      = boot_pin;
    ctl.lvl      = prot_lvl_e'(prot_lvl);
  end

  bootsel_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  bootsel_choose #(.OPT_W(OPT_W), .ADDR_W(ADDR_W), .RSS_ADDR(RSS_ADDR)) u_choose (
    .ctl(ctl), .ns0(ns_addr0), .ns1(ns_addr1), .sadr(s_addr), .chosen(chosen)
  );

  bootsel_window #(
    .ADDR_W(ADDR_W), .RSS_ADDR(RSS_ADDR),
    .SEC_WIN_BASE(SEC_WIN_BASE), .SEC_WIN_SIZE(SEC_WIN_SIZE),
    .NS_WIN_BASE(NS_WIN_BASE), .NS_WIN_SIZE(NS_WIN_SIZE)
  ) u_window (
    .sec_en(sec_en), .lvl(ctl.lvl), .cand(chosen), .checked(checked)
  );

  bootsel_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk(clk), .srst_n(srst_n), .cand(checked),
    .addr_q(fetch_addr), .valid_q(fetch_valid)
  );

  // R3
  lock_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_en && boot_lock) |-> (chosen == {s_addr, {PAD{1'b0}}}));
  // R5
  sec_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_en && prot_lvl != 2'b00) |->
      ((checked == RSS_ADDR[ADDR_W-1:0]) ||
       (checked >= SEC_WIN_BASE[ADDR_W-1:0] && checked <= SEC_LAST[ADDR_W-1:0])));
  // R6
  ns_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_en && prot_lvl == 2'b11) |->
      (checked >= NS_WIN_BASE[ADDR_W-1:0] && checked <= NS_LAST[ADDR_W-1:0]));
  // R7
  open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_lvl == 2'b00) |-> (checked == chosen));
  // R8
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (fetch_addr[PAD-1:0] == '0));
endmodule

// File: tb/boot_fetch_sel_bench.sv
`timescale 1ns/1ps
module boot_fetch_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sec_en, boot_lock, sw_sel, opt_boot, boot_pin;
  logic [1:0]  prot_lvl;
  logic [24:0] ns_addr0, ns_addr1, s_addr;
  logic [31:0] fetch_addr;
  logic        fetch_valid;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  boot_fetch_sel u_boot_fetch_sel (
    .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .boot_lock(boot_lock),
    .sw_sel(sw_sel), .opt_boot(opt_boot), .boot_pin(boot_pin),
    .prot_lvl(prot_lvl), .ns_addr0(ns_addr0), .ns_addr1(ns_addr1),
    .s_addr(s_addr), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid)
  );

  function automatic logic [31:0] ref_addr(
    logic sec, logic lock, logic sw, logic ob, logic pin, logic [1:0] lvl,
    logic [24:0] a0, logic [24:0] a1, logic [24:0] sa);
    logic sel;
    logic [31:0] a;
    sel = sw ? pin : ~ob;
    if (!sec) begin
      a = sel ? {a1, 7'b0} : {a0, 7'b0};
      if (lvl == 2'b11 && !(a >= 32'h0800_0000 && a <= 32'h0807_FFFF)) a = 32'h0800_0000;
    end else begin
      a = (lock || !sel) ? {sa, 7'b0} : 32'h0FF8_0000;
      if (lvl != 2'b00 && !(a == 32'h0FF8_0000 || (a >= 32'h0C00_0000 && a <= 32'h0C07_FFFF)))
        a = 32'h0FF8_0000;
    end
    return a;
  endfunction

  function automatic string req_tag(logic sec, logic lock, logic [1:0] lvl, logic sw);
    if (!sec) return (lvl == 2'b11) ? "R6" : (lvl == 2'b00 ? "R7" : (sw ? "R1" : "R2"));
    if (lock) return "R3";
    return (lvl != 2'b00) ? "R5" : "R4";
  endfunction

  function automatic logic [24:0] rnd_field();
    case ($urandom_range(0, 4))
      0: return 25'h180000 + 25'($urandom_range(0, 32'hFFF));
      1: return 25'h100000 + 25'($urandom_range(0, 32'hFFF));
      2: return 25'h1FF000;
      3: return ($urandom_range(0, 1) != 0) ? 25'h181000 : 25'h101000;
      default: return 25'($urandom());
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic drive(logic s, logic l, logic sw, logic ob, logic p, logic [1:0] lv,
                       logic [24:0] a0, logic [24:0] a1, logic [24:0] sa);
    sec_en = s; boot_lock = l; sw_sel = sw; opt_boot = ob; boot_pin = p;
    prot_lvl = lv; ns_addr0 = a0; ns_addr1 = a1; s_addr = sa;
  endtask

  task automatic trial(logic s, logic l, logic sw, logic ob, logic p, logic [1:0] lv,
                       logic [24:0] a0, logic [24:0] a1, logic [24:0] sa, string tag);
    logic [31:0] exp;
    exp = ref_addr(s, l, sw, ob, p, lv, a0, a1, sa);
    @(negedge clk);
    rst_n = 1'b0;
    drive(s, l, sw, ob, p, lv, a0, a1, sa);
    @(negedge clk);
    chk("R9", {31'b0, fetch_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9", {31'b0, fetch_valid}, 32'd0);
    @(negedge clk);
    chk("R9", {31'b0, fetch_valid}, 32'd1);
    chk(tag, fetch_addr, exp);
    drive(~s, ~l, ~sw, ~ob, ~p, ~lv, rnd_field(), rnd_field(), rnd_field());
    @(negedge clk);
    @(negedge clk);
    chk("R9", fetch_addr, exp);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_B007));
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 2'b00, '0, '0, '0);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", fetch_addr, 32'd0);
    chk("R9", {31'b0, fetch_valid}, 32'd0);

    // R1 pin decides
    trial(0, 0, 1, 0, 0, 2'b01, 25'h0AAAAA, 25'h155555, 25'h0, "R1");
    trial(0, 0, 1, 1, 1, 2'b10, 25'h0AAAAA, 25'h155555, 25'h0, "R1");
    // R2 option bit decides (inverted)
    trial(0, 0, 0, 1, 1, 2'b01, 25'h012345, 25'h054321, 25'h0, "R2");
    trial(0, 0, 0, 0, 0, 2'b10, 25'h012345, 25'h054321, 25'h0, "R2");
    // R3 lock ignores selection
    trial(1, 1, 1, 0, 1, 2'b00, 25'h0, 25'h0, 25'h0ABCDE, "R3");
    trial(1, 1, 0, 0, 0, 2'b00, 25'h0, 25'h0, 25'h0ABCDE, "R3");
    // R4 secure unlocked
    trial(1, 0, 1, 0, 0, 2'b00, 25'h0, 25'h0, 25'h033333, "R4");
    trial(1, 0, 1, 0, 1, 2'b00, 25'h0, 25'h0, 25'h033333, "R4");
    // R5 window edges
    trial(1, 1, 0, 0, 0, 2'b01, 25'h0, 25'h0, 25'h180FFF, "R5");
    trial(1, 1, 0, 0, 0, 2'b11, 25'h0, 25'h0, 25'h181000, "R5");
    trial(1, 1, 0, 0, 0, 2'b10, 25'h0, 25'h0, 25'h17FFFF, "R5");
    // R6 window edges
    trial(0, 0, 1, 0, 0, 2'b11, 25'h100FFF, 25'h0, 25'h0, "R6");
    trial(0, 0, 1, 0, 1, 2'b11, 25'h0, 25'h101000, 25'h0, "R6");
    // R7 / R8 unchanged address with zero low bits
    trial(0, 0, 1, 0, 0, 2'b00, 25'h1FFFFFF, 25'h0, 25'h0, "R7");
    trial(1, 1, 0, 0, 0, 2'b00, 25'h0, 25'h0, 25'h0000001, "R8");

    for (int i = 0; i < 300; i++) begin
      logic s, l, sw, ob, p;
      logic [1:0] lv;
      logic [24:0] a0, a1, sa;
      s = 1'($urandom()); l = 1'($urandom()); sw = 1'($urandom());
      ob = 1'($urandom()); p = 1'($urandom()); lv = 2'($urandom());
      a0 = rnd_field(); a1 = rnd_field(); sa = rnd_field();
      trial(s, l, sw, ob, p, lv, a0, a1, sa, req_tag(s, l, lv, sw));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule